// File: doc/BRIEF.md
# Programmable External Bus Strobe Timer

This block times the control strobes for one external memory region across a fixed bus cycle measured in memory-clock periods. Software loads a 16-bit timing word over a plain write/read register port. The word places the address-strobe falling and rising edges and the common read/write strobe rising edge at chosen clock positions, and it carries a bit that selects the clock relationship of the cycle.

A start request with a direction bit launches one cycle. The block counts positions 0 to 31 and drives active-low address-strobe, read-strobe and write-strobe lines, an address-valid flag and a one-clock completion pulse. The timing word is copied into a working copy when a cycle is accepted, so register writes made during a cycle change only later cycles. Words that break the encoding or ordering rules raise an error flag, and while the flag condition holds no cycle is started.

Top module: `bus_strobe_timer`

## Requirements
- R1: After synchronous reset the register reads 0xEB40, all three strobes are high, and address-valid, done, error and the asynchronous-mode output are low.
- R2: Register fields: bits 15:11 give the read/write strobe release position (rw_end), bits 10:8 give the address-strobe release position (as_end), bits 7:6 give the address-strobe drop position (as_beg), and bit 2 is the mode bit (1 = asynchronous, 0 = synchronous).
- R3: Bits 5:3, 1 and 0 of the register always read as zero, whatever value was written.
- R4: The asynchronous-mode output is registered. It equals the mode bit of the word latched when the most recent cycle was accepted, and it holds that value while idle.
- R5: The edge that accepts a start puts position 0 on the outputs. Each later edge advances one position up to 31. Address-valid is high at positions 0, 1 and 2 only.
- R6: The address strobe is low at positions p with as_beg <= p < as_end. It never goes low when as_beg equals as_end.
- R7: On a read cycle (direction bit 0) the read strobe is low at positions p with 3 <= p < rw_end and the write strobe stays high. On a write cycle (direction bit 1) the roles are swapped.
- R8: Done is high for exactly the position-31 clock. The next clock is idle with all strobes high, and a new start can be accepted there.
- R9: A word with as_end = 0, as_end < as_beg, or rw_end < 3 is prohibited. From the second clock edge after such a write, the error output is high and start requests are refused. A legal word clears the error with the same latency.
- R10: A register write during a cycle can be read back at once, but the running cycle keeps the timing it started with. The next cycle uses the new word.
- R11: A start request while a cycle is running is ignored. The running cycle neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (reserved bits zero) |
| cyc_start | input | 1 | Request to begin a bus cycle |
| cyc_write | input | 1 | Cycle direction: 1 write, 0 read |
| as_n | output | 1 | Address strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| addr_vld | output | 1 | Address driven on the bus |
| cyc_done | output | 1 | One-clock pulse at the final position |
| cfg_err | output | 1 | Timing word is prohibited |
| bus_async | output | 1 | Mode of the latched cycle, 1 asynchronous |

## Verification
Bus cycles are run with several words and every strobe is compared at every position.

- The reset word on a read cycle confirms the default edge positions.
- A write cycle with short, asynchronous-mode settings shows that the write strobe, not the read strobe, is gated and that the mode follows the latched word.
- A word with equal address-strobe edges and the minimum release position shows that empty windows produce no pulse.
- One prohibited word of each kind checks that the error flag rises and that cycles are refused.
- A write in the middle of a cycle and a start in the middle of a cycle show that the running cycle keeps its timing and length.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'hEB40;
  localparam logic [CFG_W-1:0] CFG_WMASK = 16'hFFC4;

  typedef struct packed {
    logic [4:0] rw_end;
    logic [2:0] as_end;
    logic [1:0] as_beg;
    logic       mode;
  } strobe_fields_t;

  function automatic strobe_fields_t unpack_cfg(input logic [CFG_W-1:0] w);
    strobe_fields_t f;
    f.rw_end = w[15:11];
    f.as_end = w[10:8];
    f.as_beg = w[7:6];
    f.mode   = w[2];
    return f;
  endfunction
endpackage

// File: rtl/strobe_cfg_reg.sv
module strobe_cfg_reg
  import strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= CFG_RESET;
    else if (we) q <= wdata & CFG_WMASK;
  end
endmodule

// File: rtl/strobe_cfg_check.sv
module strobe_cfg_check
  import strobe_pkg::*;
#(
  parameter int RW_MIN   = 3,
  parameter int ADDR_END = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  strobe_fields_t f,
  output logic           ok,
  output logic           err
);
  localparam logic [4:0] RW_MIN_C = 5'(RW_MIN);
  localparam logic [4:0] ADR_C    = 5'(ADDR_END);

  always_comb begin
    ok = (f.as_end != 3'd0)
      && (f.as_end >= {1'b0, f.as_beg})
      && (f.rw_end >= RW_MIN_C)
      && (f.rw_end >= ADR_C);
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= !ok;
  end
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import strobe_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int CYC_END   = 31,
  parameter int RW_ASSERT = 3,
  parameter int ADDR_END  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           write,
  input  logic           cfg_ok,
  input  strobe_fields_t cfg,
  output logic           busy,
  output strobe_fields_t act,
  output logic           as_n,
  output logic           re_n,
  output logic           we_n,
  output logic           addr_vld,
  output logic           done,
  output logic           async_mode
);
  localparam logic [CNT_W-1:0] END_C = CNT_W'(CYC_END);
  localparam logic [CNT_W-1:0] RW_C  = CNT_W'(RW_ASSERT);
  localparam logic [CNT_W-1:0] ADR_C = CNT_W'(ADDR_END);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_d, wr_q, wr_d, accept;
  strobe_fields_t   act_d;
  logic             as_on, rw_on;
  logic [1:0]       rw_sel, rw_n_q;

  // Next-state: the working copy changes only when a cycle is accepted.
  always_comb begin
    accept = !busy && start && cfg_ok;
    busy_d = busy;
    cnt_d  = cnt_q;
    act_d  = act;
    wr_d   = wr_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      act_d  = cfg;
      wr_d   = write;
    end else if (busy) begin
      if (cnt_q == END_C) busy_d = 1'b0;
      else                cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  // Decode the position that the registers will hold after this edge.
  always_comb begin
    as_on  = busy_d && (cnt_d >= CNT_W'(act_d.as_beg)) && (cnt_d < CNT_W'(act_d.as_end));
    rw_on  = busy_d && (cnt_d >= RW_C) && (cnt_d < CNT_W'(act_d.rw_end));
    rw_sel = {wr_d, !wr_d};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cnt_q      <= '0;
      act        <= unpack_cfg(CFG_RESET);
      wr_q       <= 1'b0;
      as_n       <= 1'b1;
      addr_vld   <= 1'b0;
      done       <= 1'b0;
      async_mode <= 1'b0;
    end else begin
      busy       <= busy_d;
      cnt_q      <= cnt_d;
      act        <= act_d;
      wr_q       <= wr_d;
      as_n       <= !as_on;
      addr_vld   <= busy_d && (cnt_d < ADR_C);
      done       <= busy_d && (cnt_d == END_C);
      async_mode <= act_d.mode;
    end
  end

  // Read (index 0) and write (index 1) strobes share one timing window.
  for (genvar i = 0; i < 2; i++) begin : g_rw
    always_ff @(posedge clk) begin
      if (rst) rw_n_q[i] <= 1'b1;
      else     rw_n_q[i] <= !(rw_on && rw_sel[i]);
    end
  end

  assign re_n = rw_n_q[0];
  assign we_n = rw_n_q[1];
endmodule

// File: rtl/bus_strobe_timer.sv
module bus_strobe_timer
  import strobe_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int CYC_END   = 31,
  parameter int RW_ASSERT = 3,
  parameter int ADDR_END  = 3,
  parameter int RW_MIN    = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        cyc_start,
  input  logic        cyc_write,
  output logic        as_n,
  output logic        re_n,
  output logic        we_n,
  output logic        addr_vld,
  output logic        cyc_done,
  output logic        cfg_err,
  output logic        bus_async
);
  logic [CFG_W-1:0] cfg_q;
  strobe_fields_t   cur_cfg, act_cfg;
  logic             cfg_ok, seq_busy;

  strobe_cfg_reg u_reg (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata), .q(cfg_q)
  );

  assign reg_rdata = cfg_q;
  assign cur_cfg   = unpack_cfg(cfg_q);

  strobe_cfg_check #(.RW_MIN(RW_MIN), .ADDR_END(ADDR_END)) u_chk_cfg (
    .clk(clk), .rst(rst), .f(cur_cfg), .ok(cfg_ok), .err(cfg_err)
  );

  strobe_seq #(
    .CNT_W(CNT_W), .CYC_END(CYC_END), .RW_ASSERT(RW_ASSERT), .ADDR_END(ADDR_END)
  ) u_seq (
    .clk(clk), .rst(rst), .start(cyc_start), .write(cyc_write), .cfg_ok(cfg_ok),
    .cfg(cur_cfg), .busy(seq_busy), .act(act_cfg), .as_n(as_n), .re_n(re_n),
    .we_n(we_n), .addr_vld(addr_vld), .done(cyc_done), .async_mode(bus_async)
  );
endmodule

// File: rtl/strobe_timer_checker.sv
module strobe_timer_checker
  import strobe_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           cyc_start,
  input logic           as_n,
  input logic           re_n,
  input logic           we_n,
  input logic           addr_vld,
  input logic           cyc_done,
  input logic [15:0]    reg_rdata,
  input logic           busy,
  input logic           cfg_ok,
  input strobe_fields_t act_cfg
);
  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~CFG_WMASK) == 16'h0);

  assert_strobes_in_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (!as_n || !re_n || !we_n || addr_vld || cyc_done) |-> busy);

  assert_rw_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(!re_n && !we_n));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> !cyc_done);

  assert_done_ends_R8: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> (as_n && re_n && we_n && !addr_vld));

  assert_refuse_bad_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && cyc_start && !cfg_ok) |=> !busy);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !cyc_done) |=> $stable(act_cfg));

  assert_busy_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !cyc_done) |=> busy);
endmodule

bind bus_strobe_timer strobe_timer_checker u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .as_n(as_n), .re_n(re_n),
  .we_n(we_n), .addr_vld(addr_vld), .cyc_done(cyc_done), .reg_rdata(reg_rdata),
  .busy(seq_busy), .cfg_ok(cfg_ok), .act_cfg(act_cfg)
);

// File: tb/bus_strobe_timer_test.sv
`timescale 1ns/1ps
module bus_strobe_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        cyc_start = 1'b0;
  logic        cyc_write = 1'b0;
  logic        as_n, re_n, we_n, addr_vld, cyc_done, cfg_err, bus_async;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bus_strobe_timer uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cyc_start(cyc_start), .cyc_write(cyc_write),
    .as_n(as_n), .re_n(re_n), .we_n(we_n), .addr_vld(addr_vld),
    .cyc_done(cyc_done), .cfg_err(cfg_err), .bus_async(bus_async)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic write_reg(input logic [15:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(posedge clk); @(negedge clk); reg_we = 1'b0;
  endtask

  // One bus cycle; expectations come from exp_cfg. Optional mid-cycle write at
  // position 10 and mid-cycle start at position 15.
  task automatic run_cycle(input string tag, input logic wr, input logic [15:0] exp_cfg,
                           input bit mid_wr, input logic [15:0] mid_val, input bit mid_start);
    int asb, ase, rwe;
    asb = int'(exp_cfg[7:6]);
    ase = int'(exp_cfg[10:8]);
    rwe = int'(exp_cfg[15:11]);
    @(negedge clk); cyc_start = 1'b1; cyc_write = wr;
    @(posedge clk); @(negedge clk); cyc_start = 1'b0;
    for (int k = 0; k < 32; k++) begin
      bit as_lo, rw_lo;
      as_lo = (k >= asb) && (k < ase);
      rw_lo = (k >= 3) && (k < rwe);
      chk({tag, " R6 as_n"}, int'(as_n), int'(!as_lo));
      chk({tag, " R7 re_n"}, int'(re_n), int'(!(rw_lo && !wr)));
      chk({tag, " R7 we_n"}, int'(we_n), int'(!(rw_lo && wr)));
      chk({tag, " R5 addr_vld"}, int'(addr_vld), int'(k < 3));
      chk({tag, " R8 done"}, int'(cyc_done), int'(k == 31));
      if (mid_wr && k == 10) begin reg_we = 1'b1; reg_wdata = mid_val; end
      if (mid_start && k == 15) cyc_start = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_we = 1'b0; cyc_start = 1'b0;
    end
    chk({tag, " R8 idle strobes"}, int'({as_n, re_n, we_n}), 7);
    chk({tag, " R8 idle addr/done"}, int'({addr_vld, cyc_done}), 0);
    chk({tag, " R4 mode"}, int'(bus_async), int'(exp_cfg[2]));
  endtask

  task automatic t_reset();
    chk("R1 reset rdata", int'(reg_rdata), 16'hEB40);
    chk("R1 reset strobes", int'({as_n, re_n, we_n}), 7);
    chk("R1 reset flags", int'({addr_vld, cyc_done, cfg_err, bus_async}), 0);
  endtask

  task automatic t_mask();
    write_reg(16'hFFFF);
    chk("R3 reserved masked", int'(reg_rdata), 16'hFFC4);
    write_reg(16'h003B);
    chk("R3 reserved ignore", int'(reg_rdata), 16'h0000);
    write_reg(16'hEB40);
    chk("R2 readback", int'(reg_rdata), 16'hEB40);
  endtask

  task automatic t_bad(input string tag, input logic [15:0] v);
    bit stayed_idle;
    write_reg(v);
    @(posedge clk); @(negedge clk);
    chk({tag, " R9 err"}, int'(cfg_err), 1);
    stayed_idle = 1'b1;
    cyc_start = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); @(negedge clk);
      if (!as_n || !re_n || !we_n || addr_vld || cyc_done) stayed_idle = 1'b0;
    end
    cyc_start = 1'b0;
    chk({tag, " R9 refused"}, int'(stayed_idle), 1);
  endtask

  task automatic t_err_clear();
    write_reg(16'hEB40);
    @(posedge clk); @(negedge clk);
    chk("R9 err cleared", int'(cfg_err), 0);
  endtask

  task automatic t_mid_write();
    write_reg(16'hEB40);
    run_cycle("midwr", 1'b1, 16'hEB40, 1'b1, 16'h5584, 1'b0);
    chk("R10 readback", int'(reg_rdata), 16'h5584);
    chk("R10 mode held old", int'(bus_async), 0);
    run_cycle("next", 1'b0, 16'h5584, 1'b0, 16'h0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_mask();
    run_cycle("default read", 1'b0, 16'hEB40, 1'b0, 16'h0, 1'b0);
    write_reg(16'h5584);
    run_cycle("short write", 1'b1, 16'h5584, 1'b0, 16'h0, 1'b0);
    write_reg(16'h1A80);
    run_cycle("equal edges", 1'b0, 16'h1A80, 1'b0, 16'h0, 1'b0);
    t_bad("as_end zero", 16'hE840);
    t_bad("as_end<as_beg", 16'hEAC0);
    t_bad("rw_end small", 16'h1340);
    t_err_clear();
    t_mid_write();
    write_reg(16'hEB40);
    run_cycle("busy start R11", 1'b0, 16'hEB40, 1'b0, 16'h0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule